// File: doc/BRIEF.md
# Local Store Priority Arbiter

This block sits in front of a flat, untagged local SRAM that three clients share: a block-transfer (DMA) engine, the load/store unit and the instruction fetcher. On every clock it looks at the three request lines and grants the memory port to one of them for that cycle. The ranking is fixed: DMA wins over loads and stores, and those win over instruction fetch. No arbitration state is carried from one cycle to the next. The granted access goes straight to the memory as a line index, a per-lane enable and write data. For a read, the data and a valid strobe return to the winner one cycle later.

The memory is organised as wide lines, each made of several narrow lanes. Loads and stores move one narrow 16-byte lane. DMA transfers and fetches move a whole 128-byte line. A fetch line holds thirty-two 4-byte instructions. The address space is one flat range of byte addresses. Every address is legal, and there is no tag match, protection check or prefetch. A client that loses keeps its request and address asserted until it is granted.

Top module: `ls_arbiter`

## Requirements
- R1: After reset, with no request present, all grants are low, all read-valid strobes are low and the memory enable is low.
- R2: In any cycle at most one grant is high, and exactly one grant is high whenever at least one request is high. The grant is combinational in the same cycle as the request.
- R3: Priority is fixed and decided anew each cycle: DMA is granted whenever it requests, load/store is granted only when DMA is idle, and fetch is granted only when both others are idle.
- R4: A held request that loses is granted in the first cycle in which no higher-ranked client requests. The arbiter keeps no history.
- R5: A load/store access covers the 16-byte lane selected by address bits [6:4] of the line at address bits [17:7]. Address bits [3:0] are ignored, and exactly one lane enable is driven.
- R6: A DMA or fetch access covers the whole 128-byte line at address bits [17:7]. Address bits [6:0] are ignored, and all eight lane enables are driven.
- R7: A granted read raises the winner's valid strobe exactly one cycle after the grant, with its data. No other client's strobe rises, and a granted write raises no strobe.
- R8: Line data is little-endian by byte: byte b of a line sits at bits [8b+7:8b]. A fetch therefore returns instruction k (k = 0..31) at bits [32k+31:32k].
- R9: A DMA write replaces only its addressed 128-byte line, and a store replaces only its addressed 16-byte lane. All other lanes and lines keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_req | input | 1 | DMA access request |
| dma_we | input | 1 | DMA access is a write |
| dma_addr | input | 18 | DMA byte address |
| dma_wdata | input | 1024 | DMA line write data |
| dma_gnt | output | 1 | DMA granted this cycle |
| dma_rvalid | output | 1 | DMA read data valid |
| dma_rdata | output | 1024 | DMA line read data |
| lsu_req | input | 1 | Load/store request |
| lsu_we | input | 1 | Load/store access is a store |
| lsu_addr | input | 18 | Load/store byte address |
| lsu_wdata | input | 128 | Store data |
| lsu_gnt | output | 1 | Load/store granted this cycle |
| lsu_rvalid | output | 1 | Load data valid |
| lsu_rdata | output | 128 | Load data |
| ifu_req | input | 1 | Fetch request |
| ifu_addr | input | 18 | Fetch byte address |
| ifu_gnt | output | 1 | Fetch granted this cycle |
| ifu_rvalid | output | 1 | Fetch data valid |
| ifu_rdata | output | 1024 | Fetched line of 32 instructions |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_line | output | 11 | Memory line index |
| mem_lane_en | output | 8 | Per-lane enables, one per 16-byte lane |
| mem_wdata | output | 1024 | Memory write data (store data repeated across lanes) |
| mem_rdata | input | 1024 | Memory read data, one cycle after the access |

## Verification
Two functions can meet in one cycle. A new grant for one client is decided in the same cycle in which the read return of the previous winner is still on its way back. A store or DMA write can also follow at once a read of the same line. The random bench provokes both by keeping all three clients busy over a small set of lines, with a store or DMA write often landing right after a read. Each cycle is judged twice. The grants are compared with the priority the bench expects, and the strobe and data that arrive the next cycle are compared with a reference image of the store.

// File: rtl/ls_arb_pkg.sv
package ls_arb_pkg;
   localparam int unsigned NUM_CLIENTS = 3;
   // client slots, lower index ranks higher
   localparam int unsigned IDX_DMA = 0;
   localparam int unsigned IDX_LSU = 1;
   localparam int unsigned IDX_IFU = 2;

   typedef enum logic {
      ACC_NARROW = 1'b0,
      ACC_WIDE   = 1'b1
   } acc_size_e;
endpackage

// File: rtl/ls_arb_pick.sv
// Fixed-priority one-hot picker: index 0 has the highest rank.
module ls_arb_pick #(
   parameter int N = 3
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   logic [N-1:0] above;

   assign above[0] = 1'b0;
   generate
      for (genvar i = 0; i < N; i++) begin : g_slot
         assign gnt[i] = req[i] & ~above[i];
         if (i < N - 1) begin : g_chain
            assign above[i+1] = above[i] | req[i];
         end
      end
   endgenerate
endmodule

// File: rtl/ls_arb_mux.sv
// Steers the granted client's access onto the single memory port.
module ls_arb_mux #(
   parameter int N      = 3,
   parameter int LINE_W = 11,
   parameter int LANE_W = 3,
   parameter int DATA_W = 1024,
   localparam int LANES = 1 << LANE_W
) (
   input  logic [N-1:0]      gnt,
   input  logic [N-1:0]      we,
   input  logic [N-1:0]      wide,
   input  logic [LINE_W-1:0] line  [N],
   input  logic [LANE_W-1:0] lane  [N],
   input  logic [DATA_W-1:0] wdata [N],
   output logic              sel_en,
   output logic              sel_we,
   output logic [LINE_W-1:0] sel_line,
   output logic [LANE_W-1:0] sel_lane,
   output logic [DATA_W-1:0] sel_wdata,
   output logic [LANES-1:0]  sel_lane_en
);
   logic sel_wide;

   // AND-OR select, grant vector is one-hot so no priority chain is needed
   always_comb begin
      sel_we    = 1'b0;
      sel_wide  = 1'b0;
      sel_line  = '0;
      sel_lane  = '0;
      sel_wdata = '0;
      for (int i = 0; i < N; i++) begin
         sel_we    = sel_we    | (we[i] & gnt[i]);
         sel_wide  = sel_wide  | (wide[i] & gnt[i]);
         sel_line  = sel_line  | (line[i]  & {LINE_W{gnt[i]}});
         sel_lane  = sel_lane  | (lane[i]  & {LANE_W{gnt[i]}});
         sel_wdata = sel_wdata | (wdata[i] & {DATA_W{gnt[i]}});
      end
   end

   assign sel_en = |gnt;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign sel_lane_en[l] = sel_en & (sel_wide | (sel_lane == LANE_W'(l)));
      end
   endgenerate
endmodule

// File: rtl/ls_arb_return.sv
// Return path: remembers last cycle's read winner and lane.
module ls_arb_return #(
   parameter int N        = 3,
   parameter int LANE_W   = 3,
   parameter int NARROW_W = 128,
   localparam int WIDE_W  = NARROW_W << LANE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N-1:0]        gnt,
   input  logic                sel_we,
   input  logic [LANE_W-1:0]   sel_lane,
   input  logic [WIDE_W-1:0]   mem_rdata,
   output logic [N-1:0]        rvalid,
   output logic [NARROW_W-1:0] narrow_rdata
);
   logic [LANE_W-1:0] lane_q;

   generate
      for (genvar i = 0; i < N; i++) begin : g_valid
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rvalid[i] <= 1'b0;
            else        rvalid[i] <= gnt[i] & ~sel_we;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= sel_lane;
   end

   assign narrow_rdata = mem_rdata[lane_q * NARROW_W +: NARROW_W];
endmodule

// File: rtl/ls_arbiter.sv
module ls_arbiter
   import ls_arb_pkg::*;
#(
   parameter int ADDR_W       = 18,
   parameter int NARROW_BYTES = 16,
   parameter int WIDE_BYTES   = 128,
   localparam int NARROW_W    = NARROW_BYTES * 8,
   localparam int WIDE_W      = WIDE_BYTES * 8,
   localparam int LANES       = WIDE_BYTES / NARROW_BYTES,
   localparam int LANE_W      = $clog2(LANES),
   localparam int NARROW_LSB  = $clog2(NARROW_BYTES),
   localparam int WIDE_LSB    = $clog2(WIDE_BYTES),
   localparam int LINE_W      = ADDR_W - WIDE_LSB
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                dma_req,
   input  logic                dma_we,
   input  logic [ADDR_W-1:0]   dma_addr,
   input  logic [WIDE_W-1:0]   dma_wdata,
   output logic                dma_gnt,
   output logic                dma_rvalid,
   output logic [WIDE_W-1:0]   dma_rdata,
   input  logic                lsu_req,
   input  logic                lsu_we,
   input  logic [ADDR_W-1:0]   lsu_addr,
   input  logic [NARROW_W-1:0] lsu_wdata,
   output logic                lsu_gnt,
   output logic                lsu_rvalid,
   output logic [NARROW_W-1:0] lsu_rdata,
   input  logic                ifu_req,
   input  logic [ADDR_W-1:0]   ifu_addr,
   output logic                ifu_gnt,
   output logic                ifu_rvalid,
   output logic [WIDE_W-1:0]   ifu_rdata,
   output logic                mem_en,
   output logic                mem_we,
   output logic [LINE_W-1:0]   mem_line,
   output logic [LANES-1:0]    mem_lane_en,
   output logic [WIDE_W-1:0]   mem_wdata,
   input  logic [WIDE_W-1:0]   mem_rdata
);
   localparam int NCL = NUM_CLIENTS;

   // elaboration-time parameter checks
   generate
      if ((NARROW_BYTES & (NARROW_BYTES - 1)) != 0 || (WIDE_BYTES & (WIDE_BYTES - 1)) != 0) begin : g_bad_pow2
         $error("ls_arbiter: access sizes must be powers of two");
      end
      if (WIDE_BYTES <= NARROW_BYTES) begin : g_bad_ratio
         $error("ls_arbiter: wide access must exceed narrow access");
      end
      if (ADDR_W <= WIDE_LSB) begin : g_bad_addr
         $error("ls_arbiter: address too narrow for one wide line");
      end
      if (WIDE_BYTES % 4 != 0) begin : g_bad_fetch
         $error("ls_arbiter: fetch line must hold whole 4-byte instructions");
      end
   endgenerate

   logic [NCL-1:0]      c_req, c_we, c_wide, c_gnt, c_rvalid;
   logic [LINE_W-1:0]   c_line  [NCL];
   logic [LANE_W-1:0]   c_lane  [NCL];
   logic [WIDE_W-1:0]   c_wdata [NCL];
   logic [LANE_W-1:0]   sel_lane;
   logic [NARROW_W-1:0] narrow_rdata;

   // request descriptors in rank order
   assign c_req[IDX_DMA]   = dma_req;
   assign c_we[IDX_DMA]    = dma_we;
   assign c_wide[IDX_DMA]  = ACC_WIDE;
   assign c_line[IDX_DMA]  = dma_addr[ADDR_W-1:WIDE_LSB];
   assign c_lane[IDX_DMA]  = '0;
   assign c_wdata[IDX_DMA] = dma_wdata;

   assign c_req[IDX_LSU]   = lsu_req;
   assign c_we[IDX_LSU]    = lsu_we;
   assign c_wide[IDX_LSU]  = ACC_NARROW;
   assign c_line[IDX_LSU]  = lsu_addr[ADDR_W-1:WIDE_LSB];
   assign c_lane[IDX_LSU]  = lsu_addr[WIDE_LSB-1:NARROW_LSB];
   assign c_wdata[IDX_LSU] = {LANES{lsu_wdata}};

   assign c_req[IDX_IFU]   = ifu_req;
   assign c_we[IDX_IFU]    = 1'b0;
   assign c_wide[IDX_IFU]  = ACC_WIDE;
   assign c_line[IDX_IFU]  = ifu_addr[ADDR_W-1:WIDE_LSB];
   assign c_lane[IDX_IFU]  = '0;
   assign c_wdata[IDX_IFU] = '0;

   // offset bits inside an access are don't-care by definition
   logic unused_low_bits;
   assign unused_low_bits = ^{dma_addr[WIDE_LSB-1:0], ifu_addr[WIDE_LSB-1:0],
                              lsu_addr[NARROW_LSB-1:0]};

   ls_arb_pick #(.N(NCL)) u_pick (
      .req (c_req),
      .gnt (c_gnt)
   );

   ls_arb_mux #(
      .N      (NCL),
      .LINE_W (LINE_W),
      .LANE_W (LANE_W),
      .DATA_W (WIDE_W)
   ) u_mux (
      .gnt         (c_gnt),
      .we          (c_we),
      .wide        (c_wide),
      .line        (c_line),
      .lane        (c_lane),
      .wdata       (c_wdata),
      .sel_en      (mem_en),
      .sel_we      (mem_we),
      .sel_line    (mem_line),
      .sel_lane    (sel_lane),
      .sel_wdata   (mem_wdata),
      .sel_lane_en (mem_lane_en)
   );

   ls_arb_return #(
      .N        (NCL),
      .LANE_W   (LANE_W),
      .NARROW_W (NARROW_W)
   ) u_ret (
      .clk          (clk),
      .rst_n        (rst_n),
      .gnt          (c_gnt),
      .sel_we       (mem_we),
      .sel_lane     (sel_lane),
      .mem_rdata    (mem_rdata),
      .rvalid       (c_rvalid),
      .narrow_rdata (narrow_rdata)
   );

   assign dma_gnt    = c_gnt[IDX_DMA];
   assign lsu_gnt    = c_gnt[IDX_LSU];
   assign ifu_gnt    = c_gnt[IDX_IFU];
   assign dma_rvalid = c_rvalid[IDX_DMA];
   assign lsu_rvalid = c_rvalid[IDX_LSU];
   assign ifu_rvalid = c_rvalid[IDX_IFU];
   assign dma_rdata  = mem_rdata;
   assign ifu_rdata  = mem_rdata;
   assign lsu_rdata  = narrow_rdata;
endmodule

// File: rtl/ls_arbiter_chk.sv
module ls_arbiter_chk #(
   parameter int LANES = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dma_req,
   input logic             dma_we,
   input logic             dma_gnt,
   input logic             dma_rvalid,
   input logic             lsu_req,
   input logic             lsu_we,
   input logic             lsu_gnt,
   input logic             lsu_rvalid,
   input logic             ifu_req,
   input logic             ifu_gnt,
   input logic             ifu_rvalid,
   input logic [LANES-1:0] mem_lane_en
);
   assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dma_gnt, lsu_gnt, ifu_gnt}));

   assert_grant_if_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req || lsu_req || ifu_req) |-> (dma_gnt || lsu_gnt || ifu_gnt));

   assert_dma_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> dma_gnt);

   assert_ifu_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ifu_gnt |-> (!dma_req && !lsu_req));

   assert_narrow_one_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lsu_gnt |-> ($countones(mem_lane_en) == 1));

   assert_wide_all_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_gnt || ifu_gnt) |-> (&mem_lane_en));

   assert_dma_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_gnt && !dma_we) |=> dma_rvalid);

   assert_lsu_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lsu_gnt && !lsu_we) |=> lsu_rvalid);

   assert_ifu_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ifu_gnt |=> ifu_rvalid);

   assert_lsu_no_stray_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lsu_rvalid |-> $past(lsu_gnt && !lsu_we));

   assert_dma_no_stray_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dma_rvalid |-> $past(dma_gnt && !dma_we));
endmodule

bind ls_arbiter ls_arbiter_chk #(.LANES(LANES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dma_req     (dma_req),
   .dma_we      (dma_we),
   .dma_gnt     (dma_gnt),
   .dma_rvalid  (dma_rvalid),
   .lsu_req     (lsu_req),
   .lsu_we      (lsu_we),
   .lsu_gnt     (lsu_gnt),
   .lsu_rvalid  (lsu_rvalid),
   .ifu_req     (ifu_req),
   .ifu_gnt     (ifu_gnt),
   .ifu_rvalid  (ifu_rvalid),
   .mem_lane_en (mem_lane_en)
);

// File: tb/sim_ls_arbiter.sv
`timescale 1ns/1ps
module sim_ls_arbiter;
   localparam int AW = 18;
   localparam int NW = 128;
   localparam int WW = 1024;
   localparam int LW = 11;
   localparam int NLINES = 2048;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          dma_req = 0, dma_we = 0;
   logic [AW-1:0] dma_addr = '0;
   logic [WW-1:0] dma_wdata = '0;
   logic          dma_gnt, dma_rvalid;
   logic [WW-1:0] dma_rdata;
   logic          lsu_req = 0, lsu_we = 0;
   logic [AW-1:0] lsu_addr = '0;
   logic [NW-1:0] lsu_wdata = '0;
   logic          lsu_gnt, lsu_rvalid;
   logic [NW-1:0] lsu_rdata;
   logic          ifu_req = 0;
   logic [AW-1:0] ifu_addr = '0;
   logic          ifu_gnt, ifu_rvalid;
   logic [WW-1:0] ifu_rdata;
   logic          mem_en, mem_we;
   logic [LW-1:0] mem_line;
   logic [7:0]    mem_lane_en;
   logic [WW-1:0] mem_wdata;
   logic [WW-1:0] mem_rdata;

   ls_arbiter u0 (.*);

   // behavioural store driven only by the memory port
   logic [WW-1:0] store  [NLINES];
   logic [WW-1:0] shadow [NLINES];
   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) begin
            for (int l = 0; l < 8; l++)
               if (mem_lane_en[l]) store[mem_line][l*NW +: NW] <= mem_wdata[l*NW +: NW];
         end else begin
            mem_rdata <= store[mem_line];
         end
      end
   end

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // pending requests, held until granted
   bit          p_dma, p_dma_we, p_lsu, p_lsu_we, p_ifu;
   logic [AW-1:0] p_dma_addr, p_lsu_addr, p_ifu_addr;
   logic [WW-1:0] p_dma_wdata;
   logic [NW-1:0] p_lsu_wdata;
   bit gen_on = 0;
   int dma_pct = 30;

   // expected returns for the next cycle
   bit          e_v [3];
   logic [WW-1:0] e_wide_dma, e_wide_ifu;
   logic [NW-1:0] e_narrow;

   function automatic logic [AW-1:0] rand_addr();
      logic [LW-1:0] ln;
      if ($urandom % 8 == 0) ln = LW'(NLINES - 1 - ($urandom % 2));
      else                   ln = LW'($urandom % 16);
      return {ln, 7'($urandom % 128)};
   endfunction

   function automatic logic [WW-1:0] rand_line();
      logic [WW-1:0] v;
      for (int w = 0; w < 32; w++) v[w*32 +: 32] = $urandom;
      return v;
   endfunction

   function automatic logic [NW-1:0] rand_quad();
      logic [NW-1:0] v;
      for (int w = 0; w < 4; w++) v[w*32 +: 32] = $urandom;
      return v;
   endfunction

   function automatic logic [LW-1:0] line_of(input logic [AW-1:0] a);
      return a[AW-1:7];
   endfunction

   task automatic gen();
      if (!gen_on) return;
      if (!p_dma && ($urandom % 100) < dma_pct) begin
         p_dma = 1; p_dma_we = $urandom % 2; p_dma_addr = rand_addr(); p_dma_wdata = rand_line();
      end
      if (!p_lsu && $urandom % 2) begin
         p_lsu = 1; p_lsu_we = $urandom % 2; p_lsu_addr = rand_addr(); p_lsu_wdata = rand_quad();
      end
      if (!p_ifu && $urandom % 2) begin
         p_ifu = 1; p_ifu_addr = rand_addr();
      end
   endtask

   task automatic step();
      int w;
      @(negedge clk);
      // returns of last cycle (R7)
      chk(dma_rvalid == e_v[0], "R7 dma_rvalid", WW'(dma_rvalid), WW'(e_v[0]));
      chk(lsu_rvalid == e_v[1], "R7 lsu_rvalid", WW'(lsu_rvalid), WW'(e_v[1]));
      chk(ifu_rvalid == e_v[2], "R7 ifu_rvalid", WW'(ifu_rvalid), WW'(e_v[2]));
      if (e_v[0]) chk(dma_rdata == e_wide_dma, "R6 R9 dma read data", dma_rdata, e_wide_dma);
      if (e_v[1]) chk(lsu_rdata == e_narrow, "R5 R9 load data", WW'(lsu_rdata), WW'(e_narrow));
      if (e_v[2]) begin
         int k = $urandom % 32;
         chk(ifu_rdata == e_wide_ifu, "R6 fetch line", ifu_rdata, e_wide_ifu);
         chk(ifu_rdata[k*32 +: 32] == {e_wide_ifu[(4*k+3)*8 +: 8], e_wide_ifu[(4*k+2)*8 +: 8],
                                       e_wide_ifu[(4*k+1)*8 +: 8], e_wide_ifu[(4*k)*8 +: 8]},
             "R8 fetch word", WW'(ifu_rdata[k*32 +: 32]), WW'(e_wide_ifu[k*32 +: 32]));
      end
      gen();
      dma_req = p_dma; dma_we = p_dma_we; dma_addr = p_dma_addr; dma_wdata = p_dma_wdata;
      lsu_req = p_lsu; lsu_we = p_lsu_we; lsu_addr = p_lsu_addr; lsu_wdata = p_lsu_wdata;
      ifu_req = p_ifu; ifu_addr = p_ifu_addr;
      #2;
      w = p_dma ? 0 : p_lsu ? 1 : p_ifu ? 2 : 3;
      chk(dma_gnt == (w == 0), "R2 R3 R4 dma_gnt", WW'(dma_gnt), WW'(w == 0));
      chk(lsu_gnt == (w == 1), "R2 R3 R4 lsu_gnt", WW'(lsu_gnt), WW'(w == 1));
      chk(ifu_gnt == (w == 2), "R2 R3 R4 ifu_gnt", WW'(ifu_gnt), WW'(w == 2));
      if (w == 1) chk(mem_lane_en == 8'(1 << p_lsu_addr[6:4]), "R5 lane enable",
                      WW'(mem_lane_en), WW'(8'(1 << p_lsu_addr[6:4])));
      if (w == 0 || w == 2) chk(mem_lane_en == 8'hFF, "R6 lane enable", WW'(mem_lane_en), WW'(8'hFF));
      e_v[0] = 0; e_v[1] = 0; e_v[2] = 0;
      case (w)
         0: begin
            if (p_dma_we) shadow[line_of(p_dma_addr)] = p_dma_wdata;
            else begin e_v[0] = 1; e_wide_dma = shadow[line_of(p_dma_addr)]; end
            p_dma = 0;
         end
         1: begin
            if (p_lsu_we) shadow[line_of(p_lsu_addr)][p_lsu_addr[6:4]*NW +: NW] = p_lsu_wdata;
            else begin e_v[1] = 1; e_narrow = shadow[line_of(p_lsu_addr)][p_lsu_addr[6:4]*NW +: NW]; end
            p_lsu = 0;
         end
         2: begin
            e_v[2] = 1; e_wide_ifu = shadow[line_of(p_ifu_addr)];
            p_ifu = 0;
         end
         default: ;
      endcase
   endtask

   initial begin
      for (int i = 0; i < NLINES; i++) begin
         store[i] = rand_line();
         shadow[i] = store[i];
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      chk(!dma_gnt && !lsu_gnt && !ifu_gnt, "R1 grants idle", WW'({dma_gnt, lsu_gnt, ifu_gnt}), '0);
      chk(!dma_rvalid && !lsu_rvalid && !ifu_rvalid, "R1 strobes idle",
          WW'({dma_rvalid, lsu_rvalid, ifu_rvalid}), '0);
      chk(!mem_en, "R1 memory idle", WW'(mem_en), '0);

      // all three at once: DMA, then load/store, then fetch (R3)
      p_dma = 1; p_dma_we = 0; p_dma_addr = {11'd3, 7'h5A}; p_dma_wdata = '0;
      p_lsu = 1; p_lsu_we = 0; p_lsu_addr = {11'd3, 7'h3F};
      p_ifu = 1; p_ifu_addr = {11'd3, 7'h7F};
      repeat (4) step();

      // held load/store starved by DMA stream, granted once DMA stops (R4)
      p_lsu = 1; p_lsu_we = 1; p_lsu_addr = {11'd5, 7'h53}; p_lsu_wdata = rand_quad();
      for (int i = 0; i < 4; i++) begin
         p_dma = 1; p_dma_we = 1; p_dma_addr = {11'd5, 7'($urandom % 128)}; p_dma_wdata = rand_line();
         step();
      end
      step();
      // read back neighbouring lanes and lines after the store (R9)
      for (int l = 4; l < 7; l++) begin
         p_lsu = 1; p_lsu_we = 0; p_lsu_addr = {11'd5, 3'(l), 4'hF};
         step();
      end
      p_ifu = 1; p_ifu_addr = {11'd5, 7'h00}; step();
      p_ifu = 1; p_ifu_addr = {11'd6, 7'h00}; step();
      // flat space top line (R6)
      p_dma = 1; p_dma_we = 1; p_dma_addr = {11'h7FF, 7'h01}; p_dma_wdata = rand_line(); step();
      p_lsu = 1; p_lsu_we = 0; p_lsu_addr = {11'h7FF, 7'h7F}; step();
      step();

      gen_on = 1;
      for (int i = 0; i < 3000; i++) begin
         if (i == 1500) dma_pct = 5;
         step();
      end
      gen_on = 0;
      p_dma = 0; p_lsu = 0; p_ifu = 0;
      step(); step();

      begin
         int bad = 0;
         for (int i = 0; i < NLINES; i++) if (store[i] !== shadow[i]) bad++;
         chk(bad == 0, "R9 store image mismatched lines", WW'(bad), '0);
      end
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule